// File: doc/BRIEF.md
# Gap-sync serial read channel

This block is the receive half of a serial disk data path. A drive sequencer presents one data bit per bit tick. While read mode is enabled, the channel first hunts for the end of the zero-filled pre-gap. The first 1 bit it sees marks byte alignment. After that it packs incoming bits into bytes, least significant bit first.

Each completed byte is copied to a holding register that the host reads. The same event sets a byte-ready flag and, if enabled, an interrupt. A bit-serial reflected 16-bit CRC runs over the sync bit and every data bit after it. When a block is followed by its own CRC, low byte first, the CRC register returns to zero, so a nonzero status flag means the block is corrupt.

The host writes an 8-bit control value:
- bit 2 selects read mode.
- bit 4 marks CRC-field reception and suppresses the gap hunt.
- bit 6 arms the hunt on its rising edge.
- bit 7 enables the interrupt.

Read strobes for the data and status registers acknowledge the flags. The reset is asynchronous active-low and is released through a two-stage synchronizer.

Top module: `gap_sync_rx`

## Requirements
- R1: After reset, rx_data is 0, byte_ready, irq and crc_nonzero are 0, the control value is 0 and the gap hunt is not armed.
- R2: A bit is consumed only in a cycle where bit_tick is 1 and control bit 2 is 1. Otherwise the bit count, shift contents and CRC are unchanged.
- R3: The gap hunt is armed by a control write whose bit 6 is 1 when the stored bit 6 was 0. A write that leaves bit 6 at 1 does not re-arm it.
- R4: While armed and stored control bit 4 is 0, consumed 0 bits are discarded. The first consumed 1 bit ends the hunt, resets the bit count, and is not stored as data.
- R5: When the hunt is not active, each consumed bit fills the next bit position from 0 upward. On the 8th bit, the assembled byte appears on rx_data and byte_ready is 1 in the cycle after that tick.
- R6: The CRC starts at 0 and shifts right one bit per consumed bit, XORed with 0x8408 when its low bit XOR the input bit is 1. The sync bit loads the CRC with the value that a single 1 clocked into zero produces (0x8408). crc_nonzero is 1 exactly when the CRC is nonzero, and it is 0 after a block followed by its CRC sent low byte first.
- R7: On byte completion irq becomes 1 only if stored control bit 7 is 1.
- R8: If stored control bit 4 is 1 when a byte completes, bit 4 is cleared, so an armed hunt resumes from the next bit.
- R9: A data_rd or stat_rd strobe clears byte_ready and irq. A ctrl_wr strobe clears irq but not byte_ready.
- R10: A byte completion in the same cycle as a clearing strobe leaves the flags set. A control write in that cycle takes precedence over the internal clear of bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe: a disk bit is present |
| bit_in | input | 1 | Disk bit value |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_data | input | 8 | Control value written |
| data_rd | input | 1 | Data register read strobe |
| stat_rd | input | 1 | Status register read strobe |
| rx_data | output | 8 | Holding register of the last byte |
| byte_ready | output | 1 | A byte has completed since the last acknowledge |
| crc_nonzero | output | 1 | CRC register is not zero |
| irq | output | 1 | Interrupt request |

## Verification
Every result is registered once, so all outputs change at the edge that samples the tick or strobe and are due one cycle later. Stimulus is driven on the falling edge and outputs are compared on the next falling edge against a behavioural model updated at the rising edge. That puts each comparison exactly one edge after its cause. Directed sequences (a full block with CRC, a mode pause mid-byte, re-arm attempts, CRC-field suppression, coincident strobes) are checked the cycle after their final tick, and a random phase follows.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  localparam int CRC_W    = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h8408;
  localparam int CTL_W    = 8;
  // control bit positions decoded by the channel
  localparam int CB_READ  = 2;
  localparam int CB_CRCF  = 4;
  localparam int CB_ARM   = 6;
  localparam int CB_IRQEN = 7;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    crc_step = (c >> 1) ^ (((c[0] ^ b) != 1'b0) ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/gsr_crc.sv
module gsr_crc
  import gsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_hit,
  input  logic             data_take,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_q
);
  logic [CRC_W-1:0] crc_d;
  logic             crc_en;

  always_comb begin
    crc_en = sync_hit | data_take;
    if (sync_hit) crc_d = crc_step('0, 1'b1);
    else          crc_d = crc_step(crc_q, bit_in);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      crc_q <= '0;
    else if (crc_en) crc_q <= crc_d;

  // R6
  sync_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> crc_q == CRC_POLY);
  // R2
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_hit && !data_take |=> $stable(crc_q));
endmodule

// File: rtl/gsr_deser.sv
module gsr_deser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_hit,
  input  logic              data_take,
  input  logic              bit_in,
  output logic              byte_done,
  output logic [DATA_W-1:0] hold_q
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] sr_q, sr_d;

  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign sr_d[g] = (data_take && cnt_q == CW'(g)) ? bit_in : sr_q[g];
  end

  always_comb begin
    byte_done = data_take && (cnt_q == LAST);
    cnt_d     = cnt_q;
    if (sync_hit)       cnt_d = '0;
    else if (byte_done) cnt_d = '0;
    else if (data_take) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      hold_q <= '0;
    end else begin
      if (sync_hit | data_take) cnt_q <= cnt_d;
      if (data_take)            sr_q  <= sr_d;
      if (byte_done)            hold_q <= sr_d;
    end

  // R4
  sync_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> cnt_q == '0);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_hit && !data_take |=> $stable(cnt_q) && $stable(hold_q));
endmodule

// File: rtl/gsr_ctrl.sv
module gsr_ctrl
  import gsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             bit_in,
  input  logic             ctrl_wr,
  input  logic [CTL_W-1:0] ctrl_data,
  input  logic             data_rd,
  input  logic             stat_rd,
  input  logic             byte_done,
  output logic             sync_hit,
  output logic             data_take,
  output logic             ready_q,
  output logic             irq_q
);
  logic read_en_q, crcf_q, arm_q, irqen_q, hunt_q;
  logic read_en_d, crcf_d, arm_d, irqen_d, hunt_d, ready_d, irq_d;
  logic take, hunt_on, ack, arm_rise;
  logic ctrl_unused;

  assign ctrl_unused = ^{ctrl_data[5], ctrl_data[3], ctrl_data[1:0]};

  always_comb begin
    take      = bit_tick & read_en_q;
    hunt_on   = hunt_q & ~crcf_q;
    sync_hit  = take & hunt_on & bit_in;
    data_take = take & ~hunt_on;
    ack       = data_rd | stat_rd;
    arm_rise  = ctrl_wr & ~arm_q & ctrl_data[CB_ARM];

    read_en_d = read_en_q;
    crcf_d    = crcf_q;
    arm_d     = arm_q;
    irqen_d   = irqen_q;
    if (ctrl_wr) begin
      read_en_d = ctrl_data[CB_READ];
      crcf_d    = ctrl_data[CB_CRCF];
      arm_d     = ctrl_data[CB_ARM];
      irqen_d   = ctrl_data[CB_IRQEN];
    end else if (byte_done) begin
      crcf_d    = 1'b0;
    end

    hunt_d = hunt_q;
    if (arm_rise)      hunt_d = 1'b1;
    else if (sync_hit) hunt_d = 1'b0;

    ready_d = ready_q;
    if (byte_done) ready_d = 1'b1;
    else if (ack)  ready_d = 1'b0;

    irq_d = irq_q;
    if (byte_done && irqen_q) irq_d = 1'b1;
    else if (ack || ctrl_wr)  irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      read_en_q <= 1'b0;
      crcf_q    <= 1'b0;
      arm_q     <= 1'b0;
      irqen_q   <= 1'b0;
      hunt_q    <= 1'b0;
      ready_q   <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      read_en_q <= read_en_d;
      crcf_q    <= crcf_d;
      arm_q     <= arm_d;
      irqen_q   <= irqen_d;
      hunt_q    <= hunt_d;
      ready_q   <= ready_d;
      irq_q     <= irq_d;
    end

  // R5
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(byte_done));
  // R7
  irq_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ready_q);
  // R4
  hunt_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hunt_q) |-> $past(sync_hit));
  // R8
  crcf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !ctrl_wr |=> !crcf_q);
endmodule

// File: rtl/gap_sync_rx.sv
module gap_sync_rx
  import gsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              bit_in,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_data,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              byte_ready,
  output logic              crc_nonzero,
  output logic              irq
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             sync_hit, data_take, byte_done;
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  assign rst_sync_n = rst_pipe[1];

  gsr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .bit_tick(bit_tick), .bit_in(bit_in),
    .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data), .data_rd(data_rd), .stat_rd(stat_rd),
    .byte_done(byte_done), .sync_hit(sync_hit), .data_take(data_take),
    .ready_q(byte_ready), .irq_q(irq)
  );

  gsr_deser #(.DATA_W(DATA_W)) u_deser (
    .clk(clk), .rst_n(rst_sync_n), .sync_hit(sync_hit), .data_take(data_take),
    .bit_in(bit_in), .byte_done(byte_done), .hold_q(rx_data)
  );

  gsr_crc u_crc (
    .clk(clk), .rst_n(rst_sync_n), .sync_hit(sync_hit), .data_take(data_take),
    .bit_in(bit_in), .crc_q(crc_q)
  );

  assign crc_nonzero = |crc_q;

  // R2
  exclusive_take_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(sync_hit && data_take));
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> !byte_ready && !irq && !crc_nonzero);
endmodule

// File: tb/sim_gap_sync_rx.sv
`timescale 1ns/1ps
module sim_gap_sync_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0, bit_in = 1'b0, ctrl_wr = 1'b0, data_rd = 1'b0, stat_rd = 1'b0;
  logic [7:0] ctrl_data = 8'h00;
  logic [7:0] rx_data;
  logic       byte_ready, crc_nonzero, irq;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gap_sync_rx u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bit_in(bit_in),
    .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data), .data_rd(data_rd), .stat_rd(stat_rd),
    .rx_data(rx_data), .byte_ready(byte_ready), .crc_nonzero(crc_nonzero), .irq(irq)
  );

  // behavioural reference
  int m_ctrl, m_hunt, m_cnt, m_sr, m_hold, m_rdy, m_irq, m_crc;

  function automatic int crc1(int c, int b);
    int r = c >> 1;
    if (((c ^ b) & 1) != 0) r = r ^ 'h8408;
    return r & 'hFFFF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_hunt = 0; m_cnt = 0; m_sr = 0; m_hold = 0; m_rdy = 0; m_irq = 0; m_crc = 0;
    end else begin
      int take, hon, sy, dt, done, b;
      b    = bit_in;
      take = bit_tick && m_ctrl[2];
      hon  = m_hunt && !m_ctrl[4];
      sy   = take && hon && b;
      dt   = take && !hon;
      done = dt && (m_cnt == 7);
      if (ctrl_wr && !m_ctrl[6] && ctrl_data[6]) m_hunt = 1;
      else if (sy) m_hunt = 0;
      if (done) m_rdy = 1; else if (data_rd || stat_rd) m_rdy = 0;
      if (done && m_ctrl[7]) m_irq = 1; else if (data_rd || stat_rd || ctrl_wr) m_irq = 0;
      if (sy) begin
        m_crc = crc1(0, 1); m_cnt = 0;
      end else if (dt) begin
        m_crc = crc1(m_crc, b);
        if (b) m_sr = m_sr | (1 << m_cnt); else m_sr = m_sr & ~(1 << m_cnt);
        if (done) begin m_hold = m_sr; m_cnt = 0; end else m_cnt = m_cnt + 1;
      end
      if (ctrl_wr) m_ctrl = ctrl_data;
      else if (done) m_ctrl = m_ctrl & ~('h10);
    end
  end

  task automatic chk(string req, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-clock comparison
  always @(negedge clk) if (!finished) begin
    chk("R5 rx_data", rx_data, m_hold);
    chk("R5/R9 byte_ready", byte_ready, m_rdy);
    chk("R6 crc_nonzero", crc_nonzero, m_crc != 0);
    chk("R7/R9 irq", irq, m_irq);
  end

  task automatic tick(input logic b);
    bit_tick = 1'b1; bit_in = b;
    @(negedge clk);
    bit_tick = 1'b0; bit_in = 1'b0;
  endtask
  task automatic wr(input logic [7:0] v);
    ctrl_wr = 1'b1; ctrl_data = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask
  task automatic rd_data();
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
  endtask
  task automatic send(input logic [7:0] v);
    for (int i = 0; i < 8; i++) tick(v[i]);
  endtask

  int c;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 rx_data", rx_data, 0);
    chk("R1 flags", {byte_ready, irq, crc_nonzero}, 0);

    // full block: R3 R4 R5 R6 R7
    wr(8'h84); wr(8'hC4);
    repeat (5) tick(1'b0);
    tick(1'b1);
    chk("R4 sync not data", byte_ready, 0);
    chk("R6 seed", crc_nonzero, 1);
    c = crc1(0, 1);
    for (int i = 0; i < 8; i++) c = crc1(c, (8'hA5 >> i) & 1);
    send(8'hA5);
    chk("R5 byte A5", rx_data, 8'hA5);
    chk("R5 ready", byte_ready, 1);
    chk("R7 irq", irq, 1);
    rd_data();
    chk("R9 ack ready", byte_ready, 0);
    chk("R9 ack irq", irq, 0);
    wr(8'hD4);
    send(c[7:0]);
    chk("R8 crc field byte", rx_data, c & 'hFF);
    send(c[15:8]);
    chk("R6 residue zero", crc_nonzero, 0);
    // R9: ctrl write clears irq only
    wr(8'hC4);
    chk("R9 wr keeps ready", byte_ready, 1);
    chk("R9 wr clears irq", irq, 0);

    // R2: pause mid-byte
    send(8'h00); rd_data();
    for (int i = 0; i < 4; i++) tick(8'h96 >> i);
    wr(8'hC0);
    repeat (10) tick(1'b1);
    for (int i = 0; i < 6; i++) begin bit_in = i[0]; @(negedge clk); end
    wr(8'hC4);
    for (int i = 4; i < 8; i++) tick(8'h96 >> i);
    chk("R2 paused byte", rx_data, 8'h96);

    // R3: write with bit 6 already set does not re-arm
    rd_data(); wr(8'hC4);
    send(8'h00);
    chk("R3 no rearm", byte_ready, 1);
    rd_data(); wr(8'h04); wr(8'h44);
    send(8'h00);
    chk("R3/R4 rearm discards zeros", byte_ready, 0);

    // R8: armed with bit 4 set, hunt suppressed until a byte completes
    wr(8'h04); wr(8'h54);
    send(8'h3C);
    chk("R8 suppressed hunt", rx_data, 8'h3C);
    rd_data();
    send(8'h00);
    chk("R8 hunt resumes", byte_ready, 0);
    tick(1'b1); send(8'h5A);
    chk("R8 after sync", rx_data, 8'h5A);

    // R10: completion coincides with ack
    rd_data(); wr(8'hC4);
    wr(8'hD4);
    for (int i = 0; i < 7; i++) tick(1'b1);
    bit_tick = 1'b1; bit_in = 1'b0; data_rd = 1'b1; ctrl_wr = 1'b1; ctrl_data = 8'hD4;
    @(negedge clk);
    bit_tick = 1'b0; data_rd = 1'b0; ctrl_wr = 1'b0;
    chk("R10 ready wins", byte_ready, 1);
    chk("R10 byte", rx_data, 8'h7F);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      bit_tick  = ($urandom % 2) == 0;
      bit_in    = ($urandom % 3) == 0;
      ctrl_wr   = ($urandom % 23) == 0;
      ctrl_data = 8'($urandom) | 8'h04;
      if (($urandom % 5) == 0) ctrl_data[2] = 1'b0;
      data_rd   = ($urandom % 13) == 0;
      stat_rd   = ($urandom % 17) == 0;
      @(negedge clk);
    end
    bit_tick = 0; ctrl_wr = 0; data_rd = 0; stat_rd = 0;
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule